// File: doc/BRIEF.md
# SPI Master/Slave Pin Engine

This block moves one byte at a time over a four-wire serial link and controls the direction and drive of every wire itself. A mode input picks master or slave operation. As master it makes the serial clock from the system clock with a programmable divider, drives the select line low for the whole byte, and shifts a byte out on MOSI while it shifts the byte on MISO in. As slave it takes clock, select and MOSI from the pins through two-flop synchronizers, and drives MISO only while it is selected, so that several slaves can share one MISO wire.

The clock idles low. Data leaves most significant bit first. Output changes on the falling clock edge and input is sampled on the rising edge. An open-drain option lets MOSI sit on a pulled-up shared line: the pin is driven only while it sends a 0. A one-cycle done pulse marks each finished byte, and a new transmit byte is taken only while the block is idle.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset `busy`, `done`, `sck_out` and `rx_data` are all 0.
- R2: With `enable` low, all four output enables (`sck_oe`, `mosi_oe`, `miso_oe`, `ss_oe`) are 0. In master mode (`enable`=1, `master_sel`=1), `sck_oe` and `ss_oe` are 1 and `miso_oe` is 0. In slave mode (`master_sel`=0), `sck_oe`, `ss_oe` and `mosi_oe` are 0.
- R3: `miso_oe` is 1 only when `enable`=1, `master_sel`=0 and `ss_in`=0. It falls as soon as `ss_in` returns to 1.
- R4: In master mode an accepted byte is sent on MOSI most significant bit first, over eight `sck_out` periods. A peer that samples on the rising edge sees that byte, while MISO is sampled on each rising edge to build `rx_data`. `sck_out` is 0 whenever no transfer is running.
- R5: Each half period of `sck_out` lasts H system clocks, where H = `clk_div`, or 1 when `clk_div` is 0. `busy` is high for exactly 16·H cycles per master byte.
- R6: With `open_drain`=1, `mosi_out` is 0 whenever `mosi_oe` is 1, and `mosi_oe` is 1 only while the bit being sent is 0. A pulled-up line therefore carries the byte. With `open_drain`=0, `mosi_oe` stays 1 through a master transfer.
- R7: After the eighth sampled bit, `done` is high for exactly one cycle and `rx_data` holds the received byte, with the first bit received in bit 7.
- R8: `tx_valid` is ignored while `busy` is 1. A byte offered during a transfer neither changes the bits still to be sent nor starts a second transfer.
- R9: In slave mode a byte loaded while idle appears on `miso_out` MSB first, before each rising `sck_in` edge. The byte clocked in on `mosi_in` appears on `rx_data` with a `done` pulse.
- R10: In slave mode, if `ss_in` rises before the eighth bit, the transfer is dropped with no `done`, `busy` returns to 0, and the next byte is received correctly from its first bit.
- R11: In master mode `ss_out` is 0 while a byte is in progress and 1 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; when low all pins are released |
| master_sel | input | 1 | 1 = master, 0 = slave |
| open_drain | input | 1 | MOSI open-drain option |
| clk_div | input | DIV_W | Half-period length of the master clock in system cycles (0 acts as 1) |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Offer `tx_data`; taken only when not busy |
| busy | output | 1 | A byte is in progress |
| rx_data | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle pulse when a byte is complete |
| sck_in | input | 1 | Serial clock pin, input side |
| sck_out | output | 1 | Serial clock pin, output value |
| sck_oe | output | 1 | Serial clock pin output enable |
| ss_in | input | 1 | Select pin, input side (active low) |
| ss_out | output | 1 | Select pin, output value |
| ss_oe | output | 1 | Select pin output enable |
| mosi_in | input | 1 | MOSI pin, input side |
| mosi_out | output | 1 | MOSI pin, output value |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_in | input | 1 | MISO pin, input side |
| miso_out | output | 1 | MISO pin, output value |
| miso_oe | output | 1 | MISO pin output enable |

## Verification
Master bytes are exchanged with a bench peer that samples a modelled pulled-up MOSI line. Random data, random reply bytes and random divisors from 0 to 4 separate bit-order and sampling-edge faults from timing faults in the divider. All-ones and all-zeros bytes in open-drain mode show whether the enable follows the data and whether the pull-up alone carries the ones. A byte offered mid-transfer, and slave bytes cut short by a select release and then followed by a full byte, show whether the busy guard and the abort path are kept apart from normal completion. Random slave exchanges driven at a slow pin clock check the synchronizers, MISO ordering and MISO release.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    OP_OFF    = 2'd0,
    OP_MASTER = 2'd1,
    OP_SLAVE  = 2'd2
  } op_mode_e;

  typedef struct packed {
    logic mosi;
    logic ss;
    logic sck;
  } pin_sync_t;

  function automatic op_mode_e decode_mode(input logic en, input logic msel);
    if (!en) return OP_OFF;
    return msel ? OP_MASTER : OP_SLAVE;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W         = 3,
  parameter int unsigned STAGES    = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d_in[i]};
    end
    assign d_sync[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned EDGES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] clk_div,
  output logic             sck,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             active
);

  localparam int unsigned EW = $clog2(EDGES);

  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic [DIV_W-1:0] hcnt;
  logic [EW-1:0]    ecnt;
  logic             tick;

  assign tick     = active && (hcnt >= last_count(clk_div));
  assign rise_evt = tick && !sck;
  assign fall_evt = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck    <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
    end else if (abort) begin
      active <= 1'b0;
      sck    <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      sck    <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
    end else if (active) begin
      if (tick) begin
        hcnt <= '0;
        sck  <= ~sck;
        ecnt <= ecnt + 1'b1;
        if (ecnt == EW'(EDGES - 1)) active <= 1'b0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R4: the serial clock rests low outside a transfer
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

  // R5: the serial clock only moves on a divider tick (or an abort)
  p_sck_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> $past(tick || abort));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [W-1:0]         load_data,
  input  logic                 clear,
  input  logic                 sample_evt,
  input  logic                 shift_evt,
  input  logic                 sample_bit,
  output logic                 out_bit,
  output logic [$clog2(W)-1:0] bit_cnt,
  output logic [W-1:0]         rx_byte,
  output logic                 byte_done
);

  localparam int unsigned CW = $clog2(W);

  logic [W-1:0] tx_sr;
  logic [W-1:0] rx_sr;
  logic [W-1:0] rx_next;

  assign out_bit = tx_sr[W-1];
  assign rx_next = {rx_sr[W-2:0], sample_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr     <= '0;
      rx_sr     <= '0;
      rx_byte   <= '0;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        tx_sr   <= load_data;
        bit_cnt <= '0;
      end else if (clear) begin
        bit_cnt <= '0;
      end else begin
        if (sample_evt) begin
          rx_sr <= rx_next;
          if (bit_cnt == CW'(W - 1)) begin
            bit_cnt   <= '0;
            byte_done <= 1'b1;
            rx_byte   <= rx_next;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (shift_evt && bit_cnt != '0) tx_sr <= {tx_sr[W-2:0], 1'b0};
      end
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R8: the bit position only moves on a sample, load or clear
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(clear) && !$past(sample_evt)) |-> $stable(bit_cnt));

endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              master_sel,
  input  logic              open_drain,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              ss_in,
  output logic              ss_out,
  output logic              ss_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe
);

  localparam int unsigned CW     = $clog2(DATA_W);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned SYNC_W = $bits(pin_sync_t);

  op_mode_e  mode;
  logic      master_mode, slave_mode;
  pin_sync_t pins_raw, pins_s;
  logic      sck_prev, ss_prev;
  logic      sck_rise, sck_fall, ss_rise, ss_fall;
  logic      sel_s;
  logic      m_sck, m_rise, m_fall, m_active;
  logic      accept, slave_busy;
  logic      core_sample, core_shift, core_bit, core_clear, out_bit;
  logic [CW-1:0] bit_cnt;

  always_comb mode = decode_mode(enable, master_sel);
  assign master_mode = (mode == OP_MASTER);
  assign slave_mode  = (mode == OP_SLAVE);

  // pin synchronizers (slave side)
  assign pins_raw = '{mosi: mosi_in, ss: ss_in, sck: sck_in};

  spi_pin_sync #(
    .W        (SYNC_W),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pins_raw),
    .d_sync(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      ss_prev  <= 1'b1;
    end else begin
      sck_prev <= pins_s.sck;
      ss_prev  <= pins_s.ss;
    end
  end

  assign sck_rise = pins_s.sck && !sck_prev;
  assign sck_fall = !pins_s.sck && sck_prev;
  assign ss_rise  = pins_s.ss && !ss_prev;
  assign ss_fall  = !pins_s.ss && ss_prev;
  assign sel_s    = slave_mode && !pins_s.ss;

  // handshake
  assign slave_busy = slave_mode && (bit_cnt != '0);
  assign busy       = m_active || slave_busy;
  assign accept     = enable && tx_valid && !busy;

  // master clock
  spi_sck_gen #(
    .DIV_W(DIV_W),
    .EDGES(EDGES)
  ) u_sck (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept && master_sel),
    .abort   (!master_mode),
    .clk_div (clk_div),
    .sck     (m_sck),
    .rise_evt(m_rise),
    .fall_evt(m_fall),
    .active  (m_active)
  );

  // event steering into the shared shifter
  assign core_sample = master_mode ? m_rise  : (sel_s && sck_rise);
  assign core_shift  = master_mode ? m_fall  : (sel_s && sck_fall);
  assign core_bit    = master_mode ? miso_in : pins_s.mosi;
  assign core_clear  = slave_mode && (ss_rise || ss_fall);

  spi_shift_core #(
    .W(DATA_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .clear     (core_clear),
    .sample_evt(core_sample),
    .shift_evt (core_shift),
    .sample_bit(core_bit),
    .out_bit   (out_bit),
    .bit_cnt   (bit_cnt),
    .rx_byte   (rx_data),
    .byte_done (done)
  );

  // pin drive
  assign sck_out  = m_sck;
  assign sck_oe   = master_mode;
  assign ss_out   = !m_active;
  assign ss_oe    = master_mode;
  assign mosi_out = open_drain ? 1'b0 : out_bit;
  assign mosi_oe  = master_mode && (!open_drain || !out_bit);
  assign miso_out = out_bit;
  assign miso_oe  = slave_mode && !ss_in;

  // R2: a disabled block releases every pin
  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> ({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0000));

  // R3: MISO is driven only by a selected slave
  p_miso_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (enable && !master_sel && !ss_in));

  // R6: open-drain MOSI never drives a high level
  p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_drain && mosi_oe) |-> !mosi_out);

  // R10: releasing select ends any slave byte
  p_slave_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && ss_rise) |=> !busy);

  // R11: master select is held low for the whole byte
  p_ss_low_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && m_active) |-> !ss_out);

endmodule

// File: tb/spi_duplex_port_test.sv
module spi_duplex_port_test;

  localparam int CLK_P = 10;
  localparam int HP    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, master_sel = 1'b1, open_drain = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       busy, done;
  logic [7:0] rx_data;
  logic       sck_out, sck_oe, ss_out, ss_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic       sck_drv = 1'b0, ss_drv = 1'b1, mosi_drv = 1'b0;
  logic       miso_in;

  int nchk = 0, nfail = 0, done_cnt = 0;

  // bench peer for master mode
  logic [7:0] mdl_sr = 8'h00, mdl_rx = 8'h00;
  logic       mdl_on = 1'b0;
  wire        mosi_line = mosi_oe ? mosi_out : 1'b1;
  assign miso_in = mdl_sr[7];

  always @(posedge sck_out) if (mdl_on) mdl_rx <= {mdl_rx[6:0], mosi_line};
  always @(negedge sck_out) if (mdl_on) mdl_sr <= {mdl_sr[6:0], 1'b0};
  always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

  always #(CLK_P/2) clk = ~clk;

  spi_duplex_port uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master_sel(master_sel),
    .open_drain(open_drain), .clk_div(clk_div), .tx_data(tx_data),
    .tx_valid(tx_valid), .busy(busy), .rx_data(rx_data), .done(done),
    .sck_in(sck_drv), .sck_out(sck_out), .sck_oe(sck_oe),
    .ss_in(ss_drv), .ss_out(ss_out), .ss_oe(ss_oe),
    .mosi_in(mosi_drv), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe)
  );

  function automatic int exp_half(input int div);
    return (div == 0) ? 1 : div;
  endfunction

  function automatic int exp_busy_cycles(input int div);
    return 16 * exp_half(div);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] reply,
                             input int div, input bit od, input bit poke);
    int cycles = 0, d0, od_bad = 0, oe_on = 0, ss_hi = 0;
    @(negedge clk);
    enable = 1'b1; master_sel = 1'b1; open_drain = od; clk_div = 8'(div);
    mdl_sr <= reply; mdl_rx <= 8'h00; mdl_on = 1'b1;
    d0 = done_cnt;
    tx_data = tx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    while (busy) begin
      cycles++;
      if (od && mosi_oe && mosi_out) od_bad++;
      if (mosi_oe) oe_on++;
      if (ss_out) ss_hi++;
      if (poke && cycles == 3) begin tx_valid = 1'b1; tx_data = ~tx; end
      else tx_valid = 1'b0;
      @(negedge clk);
    end
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(mdl_rx == tx, "R4 mosi byte seen by peer", mdl_rx, tx);
    chk(rx_data == reply, "R7 rx_data after master byte", rx_data, reply);
    chk(done_cnt - d0 == 1, "R7 one done pulse", done_cnt - d0, 1);
    chk(cycles == exp_busy_cycles(div), "R5 busy length", cycles, exp_busy_cycles(div));
    chk(sck_out == 1'b0, "R4 sck idle low", sck_out, 0);
    chk(od_bad == 0, "R6 open-drain drove high", od_bad, 0);
    if (!od) chk(oe_on == cycles, "R6 push-pull enable held", oe_on, cycles);
    if (od && tx == 8'hFF) chk(oe_on == 0, "R6 ones left to pull-up", oe_on, 0);
    chk(ss_hi == 0 && ss_out == 1'b1, "R11 ss low during byte", ss_hi, 0);
    if (poke) chk(busy == 1'b0 && mdl_rx == tx, "R8 mid-byte offer ignored", busy, 0);
    mdl_on = 1'b0;
  endtask

  task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] stx, input int nbits);
    logic [7:0] got = 8'h00;
    int d0;
    @(negedge clk);
    enable = 1'b1; master_sel = 1'b0;
    tx_data = stx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    d0 = done_cnt;
    ss_drv = 1'b0;
    repeat (HP) @(negedge clk);
    chk(miso_oe == 1'b1, "R3 miso driven when selected", miso_oe, 1);
    chk({sck_oe, mosi_oe, ss_oe} == 3'b000, "R2 slave pins are inputs", {sck_oe, mosi_oe, ss_oe}, 0);
    for (int i = 0; i < nbits; i++) begin
      mosi_drv = mtx[7-i];
      repeat (HP) @(negedge clk);
      got[7-i] = miso_out;
      sck_drv = 1'b1;
      repeat (HP) @(negedge clk);
      sck_drv = 1'b0;
    end
    repeat (HP) @(negedge clk);
    ss_drv = 1'b1;
    #1;
    chk(miso_oe == 1'b0, "R3 miso released on deselect", miso_oe, 0);
    repeat (HP) @(negedge clk);
    if (nbits == 8) begin
      chk(rx_data == mtx, "R9 slave rx_data", rx_data, mtx);
      chk(got == stx, "R9 slave miso byte", got, stx);
      chk(done_cnt - d0 == 1, "R7 slave done pulse", done_cnt - d0, 1);
    end else begin
      chk(done_cnt == d0, "R10 no done on abort", done_cnt - d0, 0);
      chk(busy == 1'b0, "R10 idle after abort", busy, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL R4 watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && sck_out == 1'b0 && rx_data == 8'h00,
        "R1 reset state", {busy, done, sck_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && rx_data == 8'h00, "R1 idle after reset", busy, 0);

    // disabled: pins released, offers ignored
    tx_data = 8'h5A; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0000, "R2 disabled releases pins",
        {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
    chk(busy == 1'b0, "R2 disabled ignores tx_valid", busy, 0);

    // master directions
    enable = 1'b1; master_sel = 1'b1;
    @(negedge clk);
    chk(sck_oe && ss_oe && !miso_oe, "R2 master pin directions",
        {sck_oe, ss_oe, miso_oe}, 3'b110);

    // directed master corners
    master_xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0);
    master_xfer(8'hFF, 8'h00, 2, 1'b1, 1'b0);
    master_xfer(8'h00, 8'hFF, 3, 1'b1, 1'b0);
    master_xfer(8'h81, 8'h7E, 1, 1'b0, 1'b1);

    // random master bytes
    for (int k = 0; k < 12; k++)
      master_xfer(8'($urandom), 8'($urandom), int'($urandom % 5), 1'($urandom), 1'($urandom));

    // slave: full, aborted, then full again
    slave_xfer(8'hC3, 8'h96, 8);
    slave_xfer(8'hF0, 8'h0F, 3);
    slave_xfer(8'h5A, 8'hE1, 8);
    for (int k = 0; k < 6; k++)
      slave_xfer(8'($urandom), 8'($urandom), 8);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule